// File: doc/BRIEF.md
# Redundant Binary Product Finisher

This block is the back end of a signed 8x8 multiplier built on redundant binary arithmetic. Upstream logic Booth-encodes the operands and hands over the partial products already folded into redundant binary rows. Each row is a pair of ordinary binary vectors: a plus word and a minus word. At every bit position the two bits together form one digit in {-1, 0, +1}. The whole row is worth the plus word minus the minus word.

The finisher adds the rows in a binary tree of carry-free digit adders. It then subtracts the two words of the surviving row with a logarithmic-depth prefix adder, which gives the product in two's complement form. For an N-bit multiplier the block takes N/4 rows, which is two rows at the default width. It accepts no separate correction row. A single input strobe marks a valid set of rows. The product and its valid flag are registered.

Top module: `rbf_finisher`

## Requirements
- R1: A synchronous active-high reset clears `product` to zero and `out_valid` to 0. When `rst` and `in_valid` are both high in the same cycle, the reset wins and nothing is captured.
- R2: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high, outside reset.
- R3: Each digit is the bit pair (plus bit, minus bit) at one position. Equal bits (0,0 or 1,1) mean 0, (1,0) means +1 and (0,1) means -1. A row whose two words are identical therefore contributes nothing to the product.
- R4: One cycle after `in_valid`, `product` equals the sum over all rows of (plus word - minus word), taken modulo 2^(2N) as a two's complement number. Row r occupies bits [r*2N +: 2N] of each row bus.
- R5: The rows of a radix-4 Booth product of 38 and -47 yield -1786 (16'hF906).
- R6: While `in_valid` is low, `product` keeps its value.
- R7: Sets of rows offered on consecutive cycles each give their own product, in order, with no idle cycle between them.
- R8: The operand extremes (-128 x -128 = 16384, -128 x 127 = -16256, 127 x 127 = 16129) come out exactly, despite the intermediate digit transfers that wrap out of the top position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Rows on the buses are valid this cycle |
| row_pos | input | ROWS*2*OP_W (32) | Plus words of all rows, row 0 in the low bits |
| row_neg | input | ROWS*2*OP_W (32) | Minus words of all rows, row 0 in the low bits |
| out_valid | output | 1 | `product` was updated on the last edge |
| product | output | 2*OP_W (16) | Two's complement product |

## Verification
Two events can land on the same clock edge. One is a reset. The other is the capture of a new set of rows, or, with back-to-back strobes, the output of one product while the next is being taken. The bench raises `rst` and `in_valid` together with nonzero rows and expects a zero product with the flag low. It also streams several sets of rows on consecutive cycles and expects each product to appear, in order, on the edge after its strobe. The arithmetic is checked against X*Y, using rows built by a Booth row model inside the bench. It is also checked against hand-made rows with equal bit pairs.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  // Default multiplier operand width
  localparam int RBF_OP_W = 8;

  // Radix-4 Booth rows folded pairwise into redundant binary rows
  function automatic int rbf_rows(input int op_w);
    return op_w / 4;
  endfunction
endpackage

// File: rtl/rbf_digit_add.sv
// Carry-free addition of two redundant binary rows (two-level transfer scheme)
module rbf_digit_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_pos,
  input  logic [W-1:0] a_neg,
  input  logic [W-1:0] b_pos,
  input  logic [W-1:0] b_neg,
  output logic [W-1:0] z_pos,
  output logic [W-1:0] z_neg
);
  logic [W-1:0] ap, an, bp, bn;
  logic [W-1:0] s_p1, s_m1, nn, wp, wn, tpi, tni;
  logic [W-2:0] s_p2, s_m2, tp, tn;

  // canonical digits: equal bit pairs become zero
  assign ap = a_pos & ~a_neg;
  assign an = a_neg & ~a_pos;
  assign bp = b_pos & ~b_neg;
  assign bn = b_neg & ~b_pos;

  // per-position digit sum classes
  assign s_p1 = (ap & ~bp & ~bn) | (bp & ~ap & ~an);
  assign s_m1 = (an & ~bp & ~bn) | (bn & ~ap & ~an);
  assign s_p2 = ap[W-2:0] & bp[W-2:0];
  assign s_m2 = an[W-2:0] & bn[W-2:0];

  // nn[i]: both digits at position i-1 are non-negative (true below bit 0)
  assign nn = {~(an[W-2:0] | bn[W-2:0]), 1'b1};

  // transfer digit (top transfer wraps out modulo 2^W)
  assign tp = s_p2 | (s_p1[W-2:0] &  nn[W-2:0]);
  assign tn = s_m2 | (s_m1[W-2:0] & ~nn[W-2:0]);

  // interim digit
  assign wp = (s_p1 | s_m1) & ~nn;
  assign wn = (s_p1 | s_m1) &  nn;

  assign tpi = {tp, 1'b0};
  assign tni = {tn, 1'b0};

  // final digit = interim + incoming transfer, never leaves {-1,0,1}
  assign z_pos = (wp | tpi) & ~(wn | tni);
  assign z_neg = (wn | tni) & ~(wp | tpi);
endmodule

// File: rtl/rbf_prefix_sub.sv
// diff = a - b = a + ~b + 1 using a Kogge-Stone carry network
module rbf_prefix_sub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] diff
);
  localparam int CW = W - 1;          // carries needed into bits 1..W-1
  localparam int LV = $clog2(CW);

  logic [W-1:0]  bi, pb;
  logic [CW-1:0] g [LV+1];
  logic [CW-1:0] p [LV];
  logic [W-1:0]  carry;

  assign bi = ~b;
  assign pb = a ^ bi;

  // bit 0 absorbs the +1 carry-in
  assign g[0] = {a[CW-1:1] & bi[CW-1:1], (a[0] & bi[0]) | pb[0]};
  assign p[0] = pb[CW-1:0];

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < CW; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign g[l+1][i] = g[l][i] | (p[l][i] & g[l][i-D]);
        if (l + 1 < LV) begin : g_pp
          assign p[l+1][i] = p[l][i] & p[l][i-D];
        end
      end else begin : g_pass
        assign g[l+1][i] = g[l][i];
        if (l + 1 < LV) begin : g_pp
          assign p[l+1][i] = p[l][i];
        end
      end
    end
  end

  assign carry = {g[LV], 1'b1};
  assign diff  = pb ^ carry;
endmodule

// File: rtl/rbf_finisher.sv
module rbf_finisher #(
  parameter int OP_W = rbf_pkg::RBF_OP_W,
  localparam int ROWS = rbf_pkg::rbf_rows(OP_W),
  localparam int PW   = 2 * OP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [ROWS*PW-1:0] row_pos,
  input  logic [ROWS*PW-1:0] row_neg,
  output logic               out_valid,
  output logic [PW-1:0]      product
);
  // heap-ordered reduction tree: leaves ROWS..2*ROWS-1, root at 1
  logic [PW-1:0] nd_pos [1:2*ROWS-1];
  logic [PW-1:0] nd_neg [1:2*ROWS-1];
  logic [PW-1:0] diff;

  for (genvar r = 0; r < ROWS; r++) begin : g_leaf
    assign nd_pos[ROWS+r] = row_pos[r*PW +: PW];
    assign nd_neg[ROWS+r] = row_neg[r*PW +: PW];
  end

  for (genvar k = 1; k < ROWS; k++) begin : g_node
    rbf_digit_add #(.W(PW)) u_add (
      .a_pos(nd_pos[2*k]),   .a_neg(nd_neg[2*k]),
      .b_pos(nd_pos[2*k+1]), .b_neg(nd_neg[2*k+1]),
      .z_pos(nd_pos[k]),     .z_neg(nd_neg[k])
    );
  end

  rbf_prefix_sub #(.W(PW)) u_conv (
    .a(nd_pos[1]), .b(nd_neg[1]), .diff(diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      product   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= diff;
    end
  end
endmodule

// File: rtl/rbf_finisher_chk.sv
module rbf_finisher_chk #(
  parameter int ROWS = 2,
  parameter int PW   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [ROWS*PW-1:0] row_pos,
  input logic [ROWS*PW-1:0] row_neg,
  input logic               out_valid,
  input logic [PW-1:0]      product
);
  logic [PW-1:0] ref_sum;
  always_comb begin
    ref_sum = '0;
    for (int r = 0; r < ROWS; r++)
      ref_sum = ref_sum + row_pos[r*PW +: PW] - row_neg[r*PW +: PW];
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (product == '0) && !out_valid);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_sum_matches_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> product == $past(ref_sum));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(product));
endmodule

bind rbf_finisher rbf_finisher_chk #(.ROWS(ROWS), .PW(PW)) u_chk (.*);

// File: tb/tb_rbf_finisher.sv
module tb_rbf_finisher;
  localparam int OP_W = 8;
  localparam int ROWS = OP_W / 4;
  localparam int PW   = 2 * OP_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [ROWS*PW-1:0] row_pos = '0;
  logic [ROWS*PW-1:0] row_neg = '0;
  logic out_valid;
  logic [PW-1:0] product;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  rbf_finisher dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .row_pos(row_pos), .row_neg(row_neg),
    .out_valid(out_valid), .product(product)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Booth radix-4 partial product j of x*y, 16-bit
  function automatic logic [PW-1:0] booth_pp(input int x, input logic [OP_W-1:0] y, input int j);
    int ym, d;
    ym = (j == 0) ? 0 : int'(y[2*j-1]);
    d  = -2 * int'(y[2*j+1]) + int'(y[2*j]) + ym;
    return PW'(d * x * (1 << (2 * j)));
  endfunction

  // pair Booth rows: row r = pp[2r] - (-pp[2r+1])
  task automatic load_rows(input int x, input int y);
    logic [OP_W-1:0] yb;
    yb = OP_W'(y);
    for (int r = 0; r < ROWS; r++) begin
      row_pos[r*PW +: PW] = booth_pp(x, yb, 2*r);
      row_neg[r*PW +: PW] = PW'(0) - booth_pp(x, yb, 2*r+1);
    end
  endtask

  task automatic one_product(input string req, input int x, input int y);
    @(negedge clk);
    load_rows(x, y);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {15'd0, out_valid}, 16'd1);
    chk(req, product, PW'(x * y));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", product, '0);
    chk("R1", {15'd0, out_valid}, 16'd0);
    rst = 1'b0;
  endtask

  task automatic t_known;  // R5
    one_product("R5", 38, -47);
    chk("R5", product, 16'hF906);
  endtask

  task automatic t_equal_pairs;  // R3
    @(negedge clk);
    row_pos = {16'hFFFF, 16'h5A3C};
    row_neg = {16'hFFFF, 16'h5A3C};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3", product, 16'h0000);
    // row 0 all (1,1), row 1 = +1 at bit 3 and -1 at bit 0 -> 7
    @(negedge clk);
    row_pos = {16'h0008, 16'hFFFF};
    row_neg = {16'h0001, 16'hFFFF};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3", product, 16'd7);
  endtask

  task automatic t_raw_rows;  // R4 with arbitrary non-canonical words
    for (int i = 0; i < 20; i++) begin
      logic [PW-1:0] e;
      @(negedge clk);
      row_pos = {$urandom, $urandom} [ROWS*PW-1:0];
      row_neg = {$urandom, $urandom} [ROWS*PW-1:0];
      e = row_pos[PW-1:0] - row_neg[PW-1:0] + row_pos[2*PW-1:PW] - row_neg[2*PW-1:PW];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R4", product, e);
    end
  endtask

  task automatic t_random;  // R4 through Booth rows
    for (int i = 0; i < 60; i++) begin
      int x, y;
      x = int'($signed(8'($urandom)));
      y = int'($signed(8'($urandom)));
      one_product("R4", x, y);
    end
  endtask

  task automatic t_extremes;  // R8
    one_product("R8", -128, -128);
    chk("R8", product, 16'd16384);
    one_product("R8", -128, 127);
    one_product("R8", 127, 127);
    one_product("R8", 0, -128);
  endtask

  task automatic t_hold;  // R6, R2
    @(negedge clk);
    load_rows(-99, 77);
    in_valid = 1'b1;
    @(negedge clk);
    load_rows(55, 55);  // new rows, strobe low
    in_valid = 1'b0;
    chk("R6", product, PW'(-99 * 77));
    repeat (3) @(negedge clk);
    chk("R6", product, PW'(-99 * 77));
    chk("R2", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_back_to_back;  // R7
    @(negedge clk);
    load_rows(12, -5);
    in_valid = 1'b1;
    @(negedge clk);
    load_rows(-77, -3);
    chk("R7", product, PW'(12 * -5));
    chk("R7", {15'd0, out_valid}, 16'd1);
    @(negedge clk);
    load_rows(101, 64);
    chk("R7", product, PW'(-77 * -3));
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", product, PW'(101 * 64));
    chk("R7", {15'd0, out_valid}, 16'd1);
  endtask

  task automatic t_reset_collision;  // R1
    @(negedge clk);
    load_rows(90, -90);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    chk("R1", product, '0);
    chk("R1", {15'd0, out_valid}, 16'd0);
  endtask

  initial begin
    t_reset;
    t_known;
    t_equal_pairs;
    t_raw_rows;
    t_random;
    t_extremes;
    t_hold;
    t_back_to_back;
    t_reset_collision;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule